// File: doc/BRIEF.md
# Integration-Gated Illumination Pulse Generator

This block drives the light sources of a small camera. While the image sensor reports that its pixels are integrating, each light channel emits a train of equal-length pulses. Software sets the length and the number of the pulses. Outside the integration window every channel stays dark. Because light reaches the scene only while all rows are integrating, the whole frame receives the same exposure, and a rolling-shutter sensor behaves like a global-shutter one. Changing the pulse length or the pulse count changes the average light delivered per frame.

There are several channels, three by default for red, green and blue sources. Each channel has its own length and count settings, and the channels run independently of one another. Software writes the settings through a simple one-cycle write port at any time. A write lands in a staging register. The staging register is copied into the working set only at the rising edge of the next integration window, so a pulse train never changes partway through a frame.

Top module: `illum_pulse_gen`

## Requirements
- R1: After a synchronous active-low reset, every channel output is low, and every channel's staged length and count are zero, so every channel stays dark until it is programmed.
- R2: A channel output is high only in a cycle where `integ_i` is high and was also high at the previous clock edge. When `integ_i` falls, every output drops in the same cycle, because the outputs are gated combinationally.
- R3: When `integ_i` is first seen high at a clock edge and the channel's length L and count N are both nonzero, that channel's output goes high right after that edge and stays high for exactly L cycles.
- R4: Each pulse is followed by a low gap of exactly L cycles. Exactly N pulses are issued, and the output then stays low for the rest of the window. The pattern starts at cycle k=0 after the window-start edge, and the output is high when k < 2·L·N and (k mod 2L) < L.
- R5: A write with `wr_en_i`=1 goes to channel `wr_ch_i`. With `wr_sel_i`=0 it stores the pulse length from `wr_data_i[LEN_W-1:0]`. With `wr_sel_i`=1 it stores the pulse count from `wr_data_i[CNT_W-1:0]`. A write to a channel index of NUM_CH or above has no effect.
- R6: Settings written while a window is open do not change the running train. They take effect at the start of the next window, provided they are written before the cycle in which that window is first seen.
- R7: If the window closes before the train is complete, the remaining pulses are dropped. The next window restarts the full train from its first pulse.
- R8: A channel whose count is zero, or whose length is zero, stays dark for the whole window.
- R9: Each channel's pulse pattern depends only on that channel's own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| integ_i | input | 1 | High while the sensor is integrating |
| wr_en_i | input | 1 | Setting write strobe |
| wr_ch_i | input | $clog2(NUM_CH) | Channel index of the write |
| wr_sel_i | input | 1 | 0 = pulse length, 1 = pulse count |
| wr_data_i | input | LEN_W | Write data |
| led_o | output | NUM_CH | One drive enable per light channel |

## Verification
The main function is tried with three different length/count pairs running side by side. One of these channels has a zero count, which separates independent channels from shared timing and confirms the dark case. A pulse train that ends exactly at the window edge and one cut short mid-pulse show the difference between completing a train and dropping its remainder. The window that follows the cut-short one must restart from the first pulse. Writes made inside a window and writes made just before one show the difference between running settings and staged settings. A write to an out-of-range channel and a zero length complete the set of patterns whose only allowed result is darkness or no change.

// File: rtl/illum_pkg.sv
// Package: shared types for the illumination pulse generator.
// Assumes: nothing beyond IEEE 1800-2017.
package illum_pkg;

    // Field selected by a setting write
    typedef enum logic {
        FLD_LEN = 1'b0,
        FLD_CNT = 1'b1
    } fld_sel_e;

    // Phase of one channel's pulse sequencer
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ON   = 2'd1,
        PH_OFF  = 2'd2
    } pulse_ph_e;

endpackage

// File: rtl/illum_win_edge.sv
// Module: detects the opening of an integration window.
// Assumes: integ_i is synchronous to clk.
module illum_win_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic integ_i,
    output logic start_o
);
    logic integ_q;

    // Remember the window level from the previous edge
    always_ff @(posedge clk) begin
        if (!rst_n) integ_q <= 1'b0;
        else        integ_q <= integ_i;
    end

    assign start_o = integ_i & ~integ_q;
endmodule

// File: rtl/illum_cfg_bank.sv
// Module: staging and working registers for one light channel.
// A write updates the staging copy. The working length is copied from
// staging when a window opens. Assumes DATA_W >= LEN_W and DATA_W >= CNT_W.
module illum_cfg_bank
    import illum_pkg::*;
#(
    parameter int LEN_W  = 8,
    parameter int CNT_W  = 4,
    parameter int DATA_W = 8,
    parameter int CH_W   = 2,
    parameter int CH_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    output logic [LEN_W-1:0]  len_stg,
    output logic [CNT_W-1:0]  cnt_stg,
    output logic [LEN_W-1:0]  len_sh
);
    localparam logic [CH_W-1:0] MY_ID = CH_W'(CH_IDX);

    logic hit;
    assign hit = wr_en && (wr_ch == MY_ID);

    // Staging registers, written by the setting port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_stg <= '0;
            cnt_stg <= '0;
        end else if (hit) begin
            if (fld_sel_e'(wr_sel) == FLD_LEN) len_stg <= wr_data[LEN_W-1:0];
            else                               cnt_stg <= wr_data[CNT_W-1:0];
        end
    end

    // Working length, copied from staging when a window opens
    always_ff @(posedge clk) begin
        if (!rst_n)    len_sh <= '0;
        else if (load) len_sh <= len_stg;
    end
endmodule

// File: rtl/illum_pulse_seq.sv
// Module: pulse sequencer for one channel. When a window opens it starts
// a train of cnt pulses, each len cycles high followed by len cycles low.
// A closed window forces it idle. Assumes len_sh holds len_stg from the
// window-start edge onward.
module illum_pulse_seq
    import illum_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             integ_i,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_stg,
    input  logic [CNT_W-1:0] cnt_stg,
    input  logic [LEN_W-1:0] len_sh,
    output logic             led_q
);
    pulse_ph_e        ph;
    logic [LEN_W-1:0] tmr;
    logic [CNT_W-1:0] left;

    // Phase, interval timer and remaining-pulse counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph    <= PH_IDLE;
            tmr   <= '0;
            left  <= '0;
            led_q <= 1'b0;
        end else if (!integ_i) begin
            ph    <= PH_IDLE;
            led_q <= 1'b0;
        end else if (start_i) begin
            if (len_stg != '0 && cnt_stg != '0) begin
                ph    <= PH_ON;
                led_q <= 1'b1;
                tmr   <= len_stg - LEN_W'(1);
                left  <= cnt_stg;
            end else begin
                ph    <= PH_IDLE;
                led_q <= 1'b0;
            end
        end else if (ph != PH_IDLE) begin
            if (tmr != '0) begin
                tmr <= tmr - LEN_W'(1);
            end else if (ph == PH_ON) begin
                led_q <= 1'b0;
                left  <= left - CNT_W'(1);
                tmr   <= len_sh - LEN_W'(1);
                ph    <= (left == CNT_W'(1)) ? PH_IDLE : PH_OFF;
            end else begin
                led_q <= 1'b1;
                tmr   <= len_sh - LEN_W'(1);
                ph    <= PH_ON;
            end
        end
    end
endmodule

// File: rtl/illum_pulse_gen.sv
// Module: top level of the integration-gated illumination pulse generator.
// One configuration bank and one sequencer for each channel. Outputs are
// gated by the window level. Assumes LEN_W >= CNT_W and NUM_CH >= 2.
module illum_pulse_gen #(
    parameter int NUM_CH = 3,
    parameter int LEN_W  = 8,
    parameter int CNT_W  = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              integ_i,
    input  logic              wr_en_i,
    input  logic [CH_W-1:0]   wr_ch_i,
    input  logic              wr_sel_i,
    input  logic [LEN_W-1:0]  wr_data_i,
    output logic [NUM_CH-1:0] led_o
);
    logic                         start;
    logic [NUM_CH-1:0]            seq_led;
    logic [NUM_CH-1:0][LEN_W-1:0] len_stg;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_stg;
    logic [NUM_CH-1:0][LEN_W-1:0] len_sh;

    illum_win_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .integ_i (integ_i),
        .start_o (start)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        illum_cfg_bank #(
            .LEN_W  (LEN_W),
            .CNT_W  (CNT_W),
            .DATA_W (LEN_W),
            .CH_W   (CH_W),
            .CH_IDX (c)
        ) u_cfg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en_i),
            .wr_ch   (wr_ch_i),
            .wr_sel  (wr_sel_i),
            .wr_data (wr_data_i),
            .load    (start),
            .len_stg (len_stg[c]),
            .cnt_stg (cnt_stg[c]),
            .len_sh  (len_sh[c])
        );

        illum_pulse_seq #(
            .LEN_W (LEN_W),
            .CNT_W (CNT_W)
        ) u_seq (
            .clk     (clk),
            .rst_n   (rst_n),
            .integ_i (integ_i),
            .start_i (start),
            .len_stg (len_stg[c]),
            .cnt_stg (cnt_stg[c]),
            .len_sh  (len_sh[c]),
            .led_q   (seq_led[c])
        );

        // Drop the drive the moment the window closes
        assign led_o[c] = seq_led[c] & integ_i;
    end
endmodule

// File: rtl/illum_pulse_gen_chk.sv
// Module: property checker for illum_pulse_gen, attached with bind.
// Assumes the top's internal staging, working and sequencer signals.
module illum_pulse_gen_chk #(
    parameter int NUM_CH = 3,
    parameter int LEN_W  = 8,
    parameter int CNT_W  = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         integ_i,
    input logic [NUM_CH-1:0]            led_o,
    input logic [NUM_CH-1:0]            seq_led,
    input logic [NUM_CH-1:0][LEN_W-1:0] len_stg,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt_stg,
    input logic [NUM_CH-1:0][LEN_W-1:0] len_sh
);
    p_reset_dark_r1: assert property (@(posedge clk)
        !rst_n |=> (led_o == '0));

    p_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|led_o) |-> (integ_i && $past(integ_i)));

    p_close_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !integ_i |=> (seq_led == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_p
        p_first_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (integ_i && !$past(integ_i) && len_stg[c] != '0 && cnt_stg[c] != '0)
            |=> seq_led[c]);

        p_zero_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (integ_i && !$past(integ_i) && (len_stg[c] == '0 || cnt_stg[c] == '0))
            |=> !seq_led[c]);

        p_hold_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (integ_i && $past(integ_i)) |=> $stable(len_sh[c]));
    end
endmodule

bind illum_pulse_gen illum_pulse_gen_chk #(
    .NUM_CH (NUM_CH),
    .LEN_W  (LEN_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .integ_i (integ_i),
    .led_o   (led_o),
    .seq_led (seq_led),
    .len_stg (len_stg),
    .cnt_stg (cnt_stg),
    .len_sh  (len_sh)
);

// File: tb/illum_pulse_gen_test.sv
module illum_pulse_gen_test;
    localparam int NUM_CH = 3;
    localparam int LEN_W  = 8;
    localparam int CNT_W  = 4;
    localparam int CH_W   = $clog2(NUM_CH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              integ_i = 1'b0;
    logic              wr_en_i = 1'b0;
    logic [CH_W-1:0]   wr_ch_i = '0;
    logic              wr_sel_i = 1'b0;
    logic [LEN_W-1:0]  wr_data_i = '0;
    logic [NUM_CH-1:0] led_o;

    illum_pulse_gen #(.NUM_CH(NUM_CH), .LEN_W(LEN_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .integ_i(integ_i), .wr_en_i(wr_en_i),
        .wr_ch_i(wr_ch_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .led_o(led_o)
    );

    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [NUM_CH-1:0] exp_q[$];
    string             tag_q[$];

    // Bench-side view of the settings, built from the requirements
    int stg_len[NUM_CH];
    int stg_cnt[NUM_CH];
    int act_len[NUM_CH];
    int act_cnt[NUM_CH];
    int k = 0;
    bit prev_win = 1'b0;

    function automatic bit pat(int kk, int l, int n);
        return (l != 0) && (n != 0) && (kk < 2 * l * n) && ((kk % (2 * l)) < l);
    endfunction

    // Driver: applies one cycle of stimulus and queues the expected outputs
    task automatic step(input bit win, input bit we, input int ch, input bit sel,
                        input int data, input string tag);
        logic [NUM_CH-1:0] e;
        @(negedge clk);
        integ_i   = win;
        wr_en_i   = we;
        wr_ch_i   = CH_W'(ch);
        wr_sel_i  = sel;
        wr_data_i = LEN_W'(data);
        if (win && !prev_win) begin
            for (int c = 0; c < NUM_CH; c++) begin
                act_len[c] = stg_len[c];
                act_cnt[c] = stg_cnt[c];
            end
            k = 0;
        end
        for (int c = 0; c < NUM_CH; c++)
            e[c] = win ? pat(k, act_len[c], act_cnt[c]) : 1'b0;
        if (win) k++;
        prev_win = win;
        if (we && ch < NUM_CH) begin
            if (!sel) stg_len[ch] = data % (1 << LEN_W);
            else      stg_cnt[ch] = data % (1 << CNT_W);
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, 1'b0, 0, tag);
    endtask

    task automatic wr(input int ch, input bit sel, input int data, input string tag);
        step(1'b0, 1'b1, ch, sel, data, tag);
    endtask

    task automatic window(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 0, 1'b0, 0, tag);
    endtask

    // Monitor: compares the outputs after each edge against the queue
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [NUM_CH-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (led_o !== e) begin
                    n_bad++;
                    $display("FAIL %s: led_o actual %b expected %b at %0t", t, led_o, e, $time);
                end
            end
        end
    end

    initial begin
        #(2_000_000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NUM_CH; c++) begin
            stg_len[c] = 0; stg_cnt[c] = 0; act_len[c] = 0; act_cnt[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: dark after reset, even inside a window
        idle(2, "R1");
        window(6, "R1");
        idle(2, "R2");

        // R3 R4 R8 R9: three channels with different settings
        wr(0, 1'b0, 2, "R5");
        wr(0, 1'b1, 3, "R5");
        wr(1, 1'b0, 1, "R5");
        wr(1, 1'b1, 4, "R5");
        wr(2, 1'b0, 3, "R5");
        window(20, "R4");
        idle(3, "R2");

        // R6: writes inside a window wait for the next one
        wr(2, 1'b1, 2, "R9");
        window(2, "R6");
        step(1'b1, 1'b1, 0, 1'b0, 4, "R6");
        step(1'b1, 1'b1, 1, 1'b1, 1, "R6");
        window(18, "R6");
        idle(2, "R2");
        window(24, "R6");
        idle(2, "R2");

        // R7: window cut short mid-pulse, then full restart
        wr(1, 1'b0, 3, "R7");
        wr(1, 1'b1, 5, "R7");
        window(7, "R7");
        idle(2, "R7");
        window(1, "R7");
        idle(1, "R7");
        window(34, "R7");
        idle(2, "R2");

        // R5: write to an out-of-range channel index is ignored
        step(1'b0, 1'b1, 3, 1'b0, 1, "R5");
        step(1'b0, 1'b1, 3, 1'b1, 1, "R5");
        window(12, "R5");
        idle(2, "R2");

        // R8: zero length with nonzero count stays dark; R4 train ending at window edge
        wr(2, 1'b0, 0, "R8");
        wr(2, 1'b1, 5, "R8");
        wr(0, 1'b0, 5, "R4");
        wr(0, 1'b1, 2, "R4");
        window(20, "R8");
        idle(3, "R2");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule